// File: doc/BRIEF.md
# Frame-to-link phase strobe generator

This block sits in the frame clock domain of a serial data link. The frame clock runs an integer number of times faster than the link clock. The block produces a one-bit phase strobe that marks which frame-clock cycle lines up with the start of a link-clock period, so that frame-domain logic can hand words to the link layer on the right cycle.

A static parameter sets the frame-to-link ratio to 4, 2 or 1. At ratio 4 the strobe is high for one frame cycle in four (25% duty). At ratio 2 it is high for one cycle in two. At ratio 1 the two clocks are the same and the strobe stays high. Any other ratio stops elaboration with a fatal error.

The link clock comes in as a plain reference signal. A chain of flops synchronises it to the frame clock, and an edge detector finds its rising edges. A small counter runs freely modulo the ratio. Each detected rising edge forces the counter back to zero, and the strobe is registered high whenever the counter's next value is zero.

Top module: `phase_strobe_gen`

## Requirements
- R1: With RATIO=4 and a link reference of period 4 frame cycles, phase_out is high in exactly one of every four consecutive frame cycles, with three low cycles between highs.
- R2: With RATIO=2 and a link reference of period 2 frame cycles, phase_out alternates high and low on every frame cycle.
- R3: With RATIO=1, phase_out is 1 in every cycle, during reset and after it.
- R4: With RATIO 2 or 4, phase_out is 0 while rst_n is low and in the first cycle after release. From release, absent any link edge, the counter counts from zero, so the first high comes RATIO cycles after release.
- R5: A rising edge of link_ref first seen high at frame edge k makes phase_out high after frame edge k+SYNC_STAGES (k+2 by default). The strobe is then high again every RATIO cycles.
- R6: A rising edge of link_ref that arrives off the current pattern restarts the pattern from that edge. The old phase is dropped.
- R7: A rising edge of link_ref that arrives exactly where the free-running pattern would wrap leaves the pattern unchanged.
- R8: Holding link_ref at a constant level gives no edge. phase_out then keeps its free-running pattern at period RATIO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_frame | input | 1 | Frame clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_frame |
| link_ref | input | 1 | Link clock used as the alignment reference; asynchronous to the block |
| phase_out | output | 1 | Phase strobe, registered in the frame domain |

## Verification
Two things can land in the same cycle: a detected link edge that forces the counter to zero, and the counter's own wrap to zero. When the link reference keeps its period, every edge coincides with the wrap, and the bench checks on every cycle that the strobe stays uniform. The bench then stalls the link reference by one frame cycle, so the next edge lands one cycle after the wrap. It checks that the strobe follows the new edge and is not pulled back to the old phase. A reference model advances once per cycle, using only the stated sampling latency and modulo-RATIO counting, and the bench compares the strobe against it on every cycle.

// File: rtl/phase_strobe_pkg.sv
package phase_strobe_pkg;

    // Ratios the block supports between frame clock and link clock.
    function automatic bit ratio_supported(input int unsigned r);
        return (r == 1) || (r == 2) || (r == 4);
    endfunction

    // Width of a counter that runs modulo r (at least one bit).
    function automatic int unsigned mod_width(input int unsigned r);
        return (r > 2) ? $clog2(r) : 1;
    endfunction

endpackage

// File: rtl/phase_ref_sync.sv
module phase_ref_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES < 2) begin : g_bad_stages
            $fatal(1, "phase_ref_sync: STAGES must be at least 2");
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], ref_in};
        st_d.last  = st_q.chain[STAGES-1];
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Rising edge of the synchronised reference.
    assign rise = st_q.chain[STAGES-1] & ~st_q.last;

endmodule

// File: rtl/phase_counter.sv
module phase_counter
    import phase_strobe_pkg::*;
#(
    parameter int unsigned RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic phase
);

    localparam int unsigned CW                = mod_width(RATIO);
    localparam logic [CW-1:0] TOP_VAL         = CW'(RATIO - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          strobe;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == TOP_VAL) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.strobe = (st_d.cnt == '0);
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase = st_q.strobe;

endmodule

// File: rtl/phase_strobe_gen.sv
module phase_strobe_gen
    import phase_strobe_pkg::*;
#(
    parameter int unsigned RATIO       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_frame,
    input  logic rst_n,
    input  logic link_ref,
    output logic phase_out
);

    logic link_rise;

    generate
        if (!ratio_supported(RATIO)) begin : g_bad_ratio
            $fatal(1, "phase_strobe_gen: RATIO must be 1, 2 or 4");
        end else if (RATIO == 1) begin : g_same_clock
            // Frame and link clocks coincide: every cycle is a phase cycle.
            logic unused_inputs;
            assign unused_inputs = clk_frame ^ rst_n ^ link_ref;
            assign link_rise     = 1'b0;
            assign phase_out     = 1'b1;
        end else begin : g_divided
            phase_ref_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk    (clk_frame),
                .rst_n  (rst_n),
                .ref_in (link_ref),
                .rise   (link_rise)
            );

            phase_counter #(
                .RATIO (RATIO)
            ) u_ctr (
                .clk   (clk_frame),
                .rst_n (rst_n),
                .rise  (link_rise),
                .phase (phase_out)
            );
        end
    endgenerate

endmodule

// File: rtl/phase_strobe_chk.sv
module phase_strobe_chk #(
    parameter int unsigned RATIO = 4
) (
    input logic clk,
    input logic rst_n,
    input logic phase,
    input logic rise
);

    localparam int unsigned GW = $clog2(RATIO + 2);

    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          was_rst_q;

    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (phase) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != {GW{1'b1}}) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    generate
        if (RATIO > 1) begin : g_props
            // R1 / R2: without a new link edge a high strobe lasts one cycle
            assert_single_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (phase && !rise) |=> !phase);

            // R2: never RATIO or more low cycles in a row once the pattern has begun
            assert_max_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_q && !phase) |-> (gap_q < GW'(RATIO - 1)));

            // R4: first cycle after reset release shows a low strobe
            assert_reset_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
                was_rst_q |-> !phase);

            // R5: a detected link edge puts the strobe high on the next cycle
            assert_realign_R5: assert property (@(posedge clk) disable iff (!rst_n)
                rise |=> phase);
        end
    endgenerate

endmodule

bind phase_strobe_gen phase_strobe_chk #(.RATIO(RATIO)) u_chk (
    .clk   (clk_frame),
    .rst_n (rst_n),
    .phase (phase_out),
    .rise  (link_rise)
);

// File: tb/phase_strobe_gen_tb.sv
module phase_strobe_gen_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lref4 = 1'b0;
    logic lref2 = 1'b0;
    logic lref1 = 1'b0;
    logic ph4, ph2, ph1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R4";

    always #10 clk = ~clk;   // 50 MHz

    phase_strobe_gen #(.RATIO(4)) u_dut  (.clk_frame(clk), .rst_n(rst_n), .link_ref(lref4), .phase_out(ph4));
    phase_strobe_gen #(.RATIO(2)) u_dut2 (.clk_frame(clk), .rst_n(rst_n), .link_ref(lref2), .phase_out(ph2));
    phase_strobe_gen #(.RATIO(1)) u_dut1 (.clk_frame(clk), .rst_n(rst_n), .link_ref(lref1), .phase_out(ph1));

    // reference model state, index 0: ratio 4, index 1: ratio 2
    int   mr [2] = '{4, 2};
    int   mc [2];
    logic a1 [2];
    logic a2 [2];
    logic a3 [2];
    logic mexp [2];
    // link reference drive state
    int   lc [2];
    bit   stall [2];
    bit   force_hi = 0;
    int   highs [2];

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (%s) t=%0t got=%b exp=%b", tag, cur_tag, $time, got, exp);
        end
    endtask

    task automatic step();
        logic cur;
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            cur = (i == 0) ? lref4 : lref2;
            if (!rst_n) begin
                mc[i] = 0; a1[i] = 0; a2[i] = 0; a3[i] = 0; mexp[i] = 0;
            end else begin
                if (a2[i] && !a3[i]) mc[i] = 0;
                else mc[i] = (mc[i] + 1) % mr[i];
                mexp[i] = (mc[i] == 0);
                a3[i] = a2[i]; a2[i] = a1[i]; a1[i] = cur;
            end
        end
        #1;
        for (int i = 0; i < 2; i++) begin
            if (!stall[i]) lc[i] = (lc[i] + 1) % mr[i];
        end
        lref4 = force_hi ? 1'b1 : (lc[0] < 2);
        lref2 = force_hi ? 1'b1 : (lc[1] < 1);
        lref1 = ~lref1;
        @(negedge clk);
        check("R1", ph4, mexp[0]);
        check("R2", ph2, mexp[1]);
        check("R3", ph1, 1'b1);
        if (ph4) highs[0]++;
        if (ph2) highs[1]++;
    endtask

    task automatic t_reset();
        cur_tag = "R4";
        rst_n = 1'b0;
        for (int n = 0; n < 5; n++) begin
            step();
            check("R4", ph4, 1'b0);
            check("R4", ph2, 1'b0);
            check("R3", ph1, 1'b1);
        end
    endtask

    task automatic t_lock();
        cur_tag = "R5";
        rst_n = 1'b1;
        step();
        check("R4", ph4, 1'b0);
        check("R4", ph2, 1'b0);
        for (int n = 0; n < 24; n++) step();
        cur_tag = "R7";
        highs[0] = 0; highs[1] = 0;
        for (int n = 0; n < 16; n++) step();
        check("R1", highs[0] == 4, 1'b1);
        check("R2", highs[1] == 8, 1'b1);
    endtask

    task automatic t_shift();
        int first;
        cur_tag = "R6";
        stall[0] = 1;
        step();
        stall[0] = 0;
        for (int n = 0; n < 6; n++) step();
        highs[0] = 0;
        first = -1;
        for (int n = 0; n < 12; n++) begin
            step();
            if (ph4 && first < 0) first = n;
        end
        check("R6", highs[0] == 3, 1'b1);
    endtask

    task automatic t_hold();
        cur_tag = "R8";
        force_hi = 1;
        for (int n = 0; n < 4; n++) step();
        highs[0] = 0; highs[1] = 0;
        for (int n = 0; n < 16; n++) step();
        check("R8", highs[0] == 4, 1'b1);
        check("R8", highs[1] == 8, 1'b1);
        force_hi = 0;
        cur_tag = "R5";
        for (int n = 0; n < 12; n++) step();
    endtask

    task automatic t_reset_mid();
        cur_tag = "R4";
        rst_n = 1'b0;
        for (int n = 0; n < 3; n++) begin
            step();
            check("R4", ph4, 1'b0);
            check("R4", ph2, 1'b0);
            check("R3", ph1, 1'b1);
        end
        rst_n = 1'b1;
        for (int n = 0; n < 20; n++) step();
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            mc[i] = 0; a1[i] = 0; a2[i] = 0; a3[i] = 0; mexp[i] = 0;
            lc[i] = 0; stall[i] = 0; highs[i] = 0;
        end
        t_reset();
        t_lock();
        t_shift();
        t_hold();
        t_reset_mid();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired (R1) got=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule